// File: doc/BRIEF.md
# Serial Wire Debug Mode-Switch Sequencer

This block moves a combined JTAG/serial-wire debug port into serial-wire mode. It drives the debug clock and data lines through four phases. First comes a long run of ones that resets whichever protocol the port is using. Then a 16-bit select code goes out, followed by a second long run of ones. The last phase is a short run of zeros, after which the port accepts its first serial-wire transaction. The block is the only driver of the debug clock, and it drives the data line as an output for the whole sequence.

A second start input runs a shorter sequence: the second run of ones and the trailing zeros, without the select code. This reconnects to a port that is already in serial-wire mode after a protocol error. The debug clock rate comes from a divider value that is captured when a sequence starts. When the sequence ends, a one-cycle done pulse is given.

Top module: `swj_switch_sequencer`

## Requirements
- R1: After reset, dbg_clk and dbg_dat are low and busy and done are low.
- R2: A full sequence (start_full) gives exactly 140 dbg_clk rising edges. dbg_dat sampled at those edges reads, in order: 56 ones; the 16 bits of 0xE79E, least significant bit first (0,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1); 56 ones; 12 zeros.
- R3: Each debug clock period is low for D+1 system clocks and then high for D+1 system clocks, where D is the divider value captured at start. dbg_dat changes only while dbg_clk is low.
- R4: A line-reset sequence (start_line_reset) gives exactly 68 rising edges: 56 ones followed by 12 zeros.
- R5: done is high for exactly one system clock per sequence. That clock is the one in which dbg_clk returns low after the last bit, and busy falls on the same edge.
- R6: A start pulse on either input while busy is high has no effect: the running sequence keeps its bit pattern and length, and no second sequence follows.
- R7: When start_full and start_line_reset are high in the same cycle while idle, the full sequence runs.
- R8: A change of div_value while busy has no effect on the clock timing of the running sequence.
- R9: When idle, dbg_clk and dbg_dat stay low until the next accepted start.
- R10: dbg_clk only toggles while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_full | input | 1 | Start the full mode-switch sequence (accepted only when idle) |
| start_line_reset | input | 1 | Start the line-reset-only sequence (accepted only when idle) |
| div_value | input | DIV_W | Half-period length minus one, in system clocks, captured at start |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| dbg_clk | output | 1 | Debug clock to the port |
| dbg_dat | output | 1 | Debug data to the port |

## Verification
A wrong phase or a wrong bit index shows up at the first rising edge of dbg_clk whose sampled data differs from the expected stream. That edge is at most one debug clock period after the fault. A miscounted phase length moves every later bit, so the zero run begins at the wrong edge and the total edge count is wrong when done appears. A divider fault shows as a low or high run of the wrong length on the very first half period. A fault in the idle or done handling shows as a done pulse longer than one cycle, or as clock activity after busy falls.

// File: rtl/swj_seq_pkg.sv
package swj_seq_pkg;

  typedef enum logic [1:0] {
    PH_LEAD_RST = 2'd0,
    PH_SELECT   = 2'd1,
    PH_TAIL_RST = 2'd2,
    PH_SETTLE   = 2'd3
  } swj_phase_e;

  function automatic int unsigned swj_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/swj_half_timer.sv
module swj_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_lim,
  output logic             half_done
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run)            cnt_q <= '0;
    else if (cnt_q == div_lim) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign half_done = run && (cnt_q == div_lim);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_lim));

endmodule

// File: rtl/swj_bit_source.sv
module swj_bit_source
  import swj_seq_pkg::*;
#(
  parameter int unsigned RESET_LEN = 56,
  parameter int unsigned IDLE_LEN  = 12,
  parameter int unsigned CODE_LEN  = 16,
  parameter logic [CODE_LEN-1:0] CODE = 16'hE79E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_full,
  input  logic advance,
  output logic bit_val,
  output logic last_bit
);

  localparam int unsigned MAX_LEN = swj_max3(RESET_LEN, IDLE_LEN, CODE_LEN);
  localparam int unsigned IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  swj_phase_e       phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [MAX_LEN-1:0] code_ext;
  logic             phase_end;

  assign code_ext = MAX_LEN'(CODE);

  always_comb begin
    case (phase_q)
      PH_LEAD_RST, PH_TAIL_RST: last_idx = IDX_W'(RESET_LEN - 1);
      PH_SELECT:                last_idx = IDX_W'(CODE_LEN - 1);
      default:                  last_idx = IDX_W'(IDLE_LEN - 1);
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_LEAD_RST, PH_TAIL_RST: bit_val = 1'b1;
      PH_SELECT:                bit_val = code_ext[idx_q];
      default:                  bit_val = 1'b0;
    endcase
  end

  assign phase_end = (idx_q == last_idx);
  assign last_bit  = (phase_q == PH_SETTLE) && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      idx_q   <= '0;
    end else if (load) begin
      phase_q <= load_full ? PH_LEAD_RST : PH_TAIL_RST;
      idx_q   <= '0;
    end else if (advance) begin
      if (phase_end) begin
        idx_q <= '0;
        case (phase_q)
          PH_LEAD_RST: phase_q <= PH_SELECT;
          PH_SELECT:   phase_q <= PH_TAIL_RST;
          default:     phase_q <= PH_SETTLE;
        endcase
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_index_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_idx);

  assert_settle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE && !load) |=> (phase_q == PH_SETTLE));

endmodule

// File: rtl/swj_seq_ctrl.sv
module swj_seq_ctrl #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_full,
  input  logic             start_line_reset,
  input  logic [DIV_W-1:0] div_in,
  input  logic             half_done,
  input  logic             last_bit,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic [DIV_W-1:0] div_lim,
  output logic             load,
  output logic             load_full,
  output logic             advance
);

  logic start_any;

  assign start_any = start_full | start_line_reset;
  assign load      = !busy && start_any;
  assign load_full = start_full;
  assign advance   = busy && half_done && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      div_lim <= '0;
    end else if (!busy) begin
      done <= 1'b0;
      sclk <= 1'b0;
      if (start_any) begin
        busy    <= 1'b1;
        div_lim <= div_in;
      end
    end else if (half_done) begin
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (last_bit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_divider_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_lim));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_any && !advance) |=> busy);

endmodule

// File: rtl/swj_switch_sequencer.sv
module swj_switch_sequencer #(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned RESET_LEN = 56,
  parameter int unsigned IDLE_LEN  = 12,
  parameter int unsigned CODE_LEN  = 16,
  parameter logic [CODE_LEN-1:0] SELECT_CODE = 16'hE79E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_full,
  input  logic             start_line_reset,
  input  logic [DIV_W-1:0] div_value,
  output logic             busy,
  output logic             done,
  output logic             dbg_clk,
  output logic             dbg_dat
);

  logic             half_done;
  logic             last_bit;
  logic             bit_val;
  logic             sclk;
  logic [DIV_W-1:0] div_lim;
  logic             load;
  logic             load_full;
  logic             advance;

  swj_seq_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_full       (start_full),
    .start_line_reset (start_line_reset),
    .div_in           (div_value),
    .half_done        (half_done),
    .last_bit         (last_bit),
    .busy             (busy),
    .done             (done),
    .sclk             (sclk),
    .div_lim          (div_lim),
    .load             (load),
    .load_full        (load_full),
    .advance          (advance)
  );

  swj_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div_lim   (div_lim),
    .half_done (half_done)
  );

  swj_bit_source #(
    .RESET_LEN (RESET_LEN),
    .IDLE_LEN  (IDLE_LEN),
    .CODE_LEN  (CODE_LEN),
    .CODE      (SELECT_CODE)
  ) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_full (load_full),
    .advance   (advance),
    .bit_val   (bit_val),
    .last_bit  (last_bit)
  );

  assign dbg_clk = sclk;
  assign dbg_dat = busy & bit_val;

  assert_clk_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dbg_clk);

  assert_data_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_clk && $past(dbg_clk)) |-> $stable(dbg_dat));

  assert_lines_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dbg_dat);

endmodule

// File: tb/swj_switch_sequencer_bench.sv
module swj_switch_sequencer_bench;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_full = 1'b0;
  logic             start_line_reset = 1'b0;
  logic [DIV_W-1:0] div_value = '0;
  logic             busy, done, dbg_clk, dbg_dat;

  always #5 clk = ~clk;

  swj_switch_sequencer u_swj_switch_sequencer (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_full       (start_full),
    .start_line_reset (start_line_reset),
    .div_value        (div_value),
    .busy             (busy),
    .done             (done),
    .dbg_clk          (dbg_clk),
    .dbg_dat          (dbg_dat)
  );

  int n_checks = 0;
  int n_fail   = 0;

  bit exp_q[$];
  int cur_div   = 0;
  int edges     = 0;
  int bad_runs  = 0;
  int glitches  = 0;
  int done_cnt  = 0;
  int run_len   = 0;
  int cycles    = 0;
  bit seq_done  = 1'b0;
  bit timed_out = 1'b0;
  bit prev_clk  = 1'b0;
  bit prev_dat  = 1'b0;
  bit prev_busy = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected bits at each rising debug clock edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) timed_out = 1'b1;
    if (rst_n) begin
      if (dbg_clk && !prev_clk) begin
        edges++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R6 extra edge", edges, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(dbg_dat == e, "R2/R4 data bit", int'(dbg_dat), int'(e));
        end
      end
      if (dbg_clk && prev_clk && (dbg_dat != prev_dat)) glitches++;
      if (busy && !prev_busy) begin
        run_len = 1;
      end else if (dbg_clk != prev_clk) begin
        if (prev_busy && run_len != cur_div + 1) bad_runs++;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (done) begin
        done_cnt++;
        seq_done = 1'b1;
      end
      prev_clk  = dbg_clk;
      prev_dat  = dbg_dat;
      prev_busy = busy;
    end
  end

  task automatic push_ones(int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
  endtask

  // Driver: pushes expected stream then starts the sequence
  task automatic run_seq(bit full, bit both, int div, int poke);
    logic [15:0] code;
    int exp_edges;
    int idle_bad;
    code = 16'hE79E;
    if (full || both) begin
      push_ones(56);
      for (int i = 0; i < 16; i++) exp_q.push_back(code[i]);
    end
    push_ones(56);
    for (int i = 0; i < 12; i++) exp_q.push_back(1'b0);
    exp_edges = (full || both) ? 140 : 68;
    cur_div = div; edges = 0; bad_runs = 0; glitches = 0; done_cnt = 0; seq_done = 1'b0;
    @(negedge clk);
    div_value = DIV_W'(div);
    start_full = full | both;
    start_line_reset = !full | both;
    @(negedge clk);
    start_full = 1'b0;
    start_line_reset = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start_full = !full;
      start_line_reset = full;
      div_value = DIV_W'(div + 2);
      @(negedge clk);
      start_full = 1'b0;
      start_line_reset = 1'b0;
      repeat (poke) @(negedge clk);
      start_full = 1'b1;
      @(negedge clk);
      start_full = 1'b0;
    end
    while (!seq_done && !timed_out) @(negedge clk);
    check(!timed_out, "watchdog", cycles, 150000);
    @(negedge clk);
    check(edges == exp_edges, full ? "R2/R7 edge count" : "R4/R6 edge count", edges, exp_edges);
    check(exp_q.size() == 0, "R2/R4 stream consumed", exp_q.size(), 0);
    check(bad_runs == 0, "R3/R8 half-period length", bad_runs, 0);
    check(glitches == 0, "R3 data change while clock high", glitches, 0);
    check(done_cnt == 1, "R5 done pulse width", done_cnt, 1);
    idle_bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (dbg_clk || dbg_dat || busy || done) idle_bad++;
      @(negedge clk);
    end
    check(idle_bad == 0, "R9/R10 idle lines after done, R6 no relaunch", idle_bad, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!dbg_clk && !dbg_dat && !busy && !done, "R1 reset state",
          int'({dbg_clk, dbg_dat, busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!dbg_clk && !dbg_dat && !busy && !done, "R1 state after reset release",
          int'({dbg_clk, dbg_dat, busy, done}), 0);
    run_seq(1'b1, 1'b0, 0, 0);   // R2 full, fastest clock
    run_seq(1'b1, 1'b0, 2, 0);   // R2 R3 slower clock
    run_seq(1'b0, 1'b0, 1, 0);   // R4 line reset only
    run_seq(1'b1, 1'b0, 1, 40);  // R6 R8 pokes during full
    run_seq(1'b0, 1'b0, 0, 25);  // R6 pokes during line reset
    run_seq(1'b0, 1'b1, 0, 0);   // R7 both starts together
    run_seq(1'b0, 1'b0, 3, 0);   // R4 R3 wide divider
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule